// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the 32-bit general registers of a processor whose visible register set depends on the current operating mode. Two combinational read ports and one clocked write port each take a 4-bit architectural index. A 5-bit mode input chooses which physical copies of indices 8 through 14 are visible. Indices 0 to 7 always reach the same storage. Indices 8 to 12 have a private copy for the fast-interrupt mode. Indices 13 (stack) and 14 (link) have one copy per exception mode, plus one copy shared by the user and system modes.

Index 15 is the program counter. A read of index 15 returns the current instruction address plus the pipeline offset of two instructions. A write to index 15 does not go into the general storage. It is issued as a branch request, with the low two address bits cleared, and the counter loads that target on the next edge. A separate exception port writes the link register of a target mode that is named explicitly. This lets the return address be banked in the same cycle the mode switches.

Top module: `banked_regfile`

## Requirements
- R1: Indices 0–7 address one physical register each, shared by all modes: a value written under any mode code reads back unchanged under every other mode code.
- R2: Indices 8–12 have two copies. The FIQ mode (code 10001) uses one copy and every other mode code uses the other copy.
- R3: Indices 13 and 14 each have six copies, selected by mode code. User (10000) and system (11111) share one copy. FIQ (10001), IRQ (10010), supervisor (10011), abort (10111) and undefined (11011) each have a private copy.
- R4: A read of index 15 on either read port returns `pc_o + 8`.
- R5: A write to index 15 asserts `branch_valid_o` in the same cycle, with `branch_target_o` equal to the write data with bits [1:0] cleared. `pc_o` takes that target after the next rising edge. No general register changes.
- R6: When `step_i` is high and no branch is requested, `pc_o` advances by 4 at the rising edge. With neither a step nor a branch it holds. A branch takes priority over a step.
- R7: A mode code outside the seven listed selects the user/system copies and drives `mode_err_o` high. A listed code drives `mode_err_o` low.
- R8: Reads are combinational. A write lands at the rising edge, so a read of the register being written in the same cycle returns the old value, and the new value appears in the following cycle.
- R9: When `exc_we_i` is high, `exc_link_i` is written at the rising edge into the index-14 copy of the mode given by `exc_mode_i`, regardless of `mode_i`. If the normal write port targets the same physical register in the same cycle, the exception write wins.
- R10: After reset every general register of every bank reads zero and `pc_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 5 | Current processor mode code |
| mode_err_o | output | 1 | Mode code not recognised |
| ra_idx_i | input | 4 | Read port A index |
| ra_data_o | output | 32 | Read port A data |
| rb_idx_i | input | 4 | Read port B index |
| rb_data_o | output | 32 | Read port B data |
| we_i | input | 1 | Write enable |
| wr_idx_i | input | 4 | Write index |
| wr_data_i | input | 32 | Write data |
| step_i | input | 1 | Advance program counter by one instruction |
| pc_o | output | 32 | Current instruction address |
| branch_valid_o | output | 1 | Write to index 15 this cycle |
| branch_target_o | output | 32 | Aligned branch target |
| exc_we_i | input | 1 | Exception link write enable |
| exc_mode_i | input | 5 | Mode whose link copy is written |
| exc_link_i | input | 32 | Return address to bank |

## Verification
A wrong bank selection or a lost write stays invisible until the affected physical copy is read. It then shows on a read port combinationally in the same cycle, as a value that belongs to another mode or as a stale value. The bench therefore reads each copy back under several modes, so that aliasing between copies is exposed. A program counter fault appears on `pc_o` one edge after the step or branch that caused it, and on any index-15 read in that same cycle.

// File: rtl/brf_pkg.sv
package brf_pkg;

  typedef enum logic [4:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } mode_e;

  typedef enum logic [2:0] {
    BANK_USR = 3'd0,
    BANK_FIQ = 3'd1,
    BANK_IRQ = 3'd2,
    BANK_SVC = 3'd3,
    BANK_ABT = 3'd4,
    BANK_UND = 3'd5
  } bank_e;

  localparam int NUM_BANKS  = 6;
  localparam int NUM_SHARED = 8;
  localparam int NUM_HI     = 5;
  localparam int HI_BASE    = NUM_SHARED;
  localparam int HI_FIQ     = HI_BASE + NUM_HI;
  localparam int SP_BASE    = HI_FIQ + NUM_HI;
  localparam int LR_BASE    = SP_BASE + NUM_BANKS;
  localparam int NUM_PHYS   = LR_BASE + NUM_BANKS;
  localparam int PHYS_W     = $clog2(NUM_PHYS);
  localparam int IDX_W      = 4;
  localparam int MODE_W     = 5;

endpackage

// File: rtl/brf_mode_decode.sv
module brf_mode_decode
  import brf_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output bank_e             bank_o,
  output logic              valid_o
);

  always_comb begin
    valid_o = 1'b1;
    case (mode_i)
      MODE_USR, MODE_SYS: bank_o = BANK_USR;
      MODE_FIQ:           bank_o = BANK_FIQ;
      MODE_IRQ:           bank_o = BANK_IRQ;
      MODE_SVC:           bank_o = BANK_SVC;
      MODE_ABT:           bank_o = BANK_ABT;
      MODE_UND:           bank_o = BANK_UND;
      default: begin
        bank_o  = BANK_USR;
        valid_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/brf_phys_map.sv
module brf_phys_map
  import brf_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  input  bank_e             bank_i,
  output logic [PHYS_W-1:0] phys_o,
  output logic              is_pc_o
);

  localparam int SP_IDX = 13;
  localparam int LR_IDX = 14;
  localparam int PC_IDX = 15;

  int unsigned sel;

  always_comb begin
    is_pc_o = 1'b0;
    sel     = 0;
    if (int'(idx_i) < NUM_SHARED) begin
      sel = int'(idx_i);
    end else if (int'(idx_i) < HI_BASE + NUM_HI) begin
      sel = (bank_i == BANK_FIQ) ? HI_FIQ + int'(idx_i) - HI_BASE : int'(idx_i);
    end else if (int'(idx_i) == SP_IDX) begin
      sel = SP_BASE + int'(bank_i);
    end else if (int'(idx_i) == LR_IDX) begin
      sel = LR_BASE + int'(bank_i);
    end else if (int'(idx_i) == PC_IDX) begin
      is_pc_o = 1'b1;
    end
    phys_o = PHYS_W'(sel);
  end

endmodule

// File: rtl/brf_storage.sv
module brf_storage #(
  parameter int XLEN  = 32,
  parameter int NPHYS = 30,
  parameter int AW    = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   a_addr_i,
  output logic [XLEN-1:0] a_data_o,
  input  logic [AW-1:0]   b_addr_i,
  output logic [XLEN-1:0] b_data_o,
  input  logic            w_en_i,
  input  logic [AW-1:0]   w_addr_i,
  input  logic [XLEN-1:0] w_data_i,
  input  logic            x_en_i,
  input  logic [AW-1:0]   x_addr_i,
  input  logic [XLEN-1:0] x_data_i
);

  logic [XLEN-1:0] regs_q [NPHYS];

  for (genvar g = 0; g < NPHYS; g++) begin : g_reg
    // exception write has priority over the normal port
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[g] <= '0;
      end else if (x_en_i && int'(x_addr_i) == g) begin
        regs_q[g] <= x_data_i;
      end else if (w_en_i && int'(w_addr_i) == g) begin
        regs_q[g] <= w_data_i;
      end
    end
  end

  assign a_data_o = regs_q[a_addr_i];
  assign b_data_o = regs_q[b_addr_i];

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_en_i && !(x_en_i && x_addr_i == w_addr_i))
      |=> regs_q[$past(w_addr_i)] == $past(w_data_i)); // R8

  AST_EXC_LINK_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_en_i |=> regs_q[$past(x_addr_i)] == $past(x_data_i)); // R9

  AST_READ_OLD_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_en_i && !x_en_i && a_addr_i == w_addr_i && w_data_i != a_data_o)
      |=> $past(a_data_o) != regs_q[$past(a_addr_i)]); // R8

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4,
  parameter int PC_OFFSET  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  output logic              mode_err_o,
  input  logic [IDX_W-1:0]  ra_idx_i,
  output logic [XLEN-1:0]   ra_data_o,
  input  logic [IDX_W-1:0]  rb_idx_i,
  output logic [XLEN-1:0]   rb_data_o,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [XLEN-1:0]   wr_data_i,
  input  logic              step_i,
  output logic [XLEN-1:0]   pc_o,
  output logic              branch_valid_o,
  output logic [XLEN-1:0]   branch_target_o,
  input  logic              exc_we_i,
  input  logic [MODE_W-1:0] exc_mode_i,
  input  logic [XLEN-1:0]   exc_link_i
);

  localparam logic [IDX_W-1:0] LINK_IDX   = IDX_W'(14);
  localparam logic [XLEN-1:0]  ALIGN_MASK = ~XLEN'($clog2(INSN_BYTES) > 0 ? INSN_BYTES - 1 : 0);

  bank_e cur_bank, exc_bank;
  logic  cur_valid, exc_valid;

  logic [PHYS_W-1:0] a_phys, b_phys, w_phys, x_phys;
  logic              a_pc, b_pc, w_pc, x_pc;
  logic [XLEN-1:0]   a_gpr, b_gpr;
  logic [XLEN-1:0]   pc_q, pc_read;

  brf_mode_decode u_cur_dec (.mode_i(mode_i),     .bank_o(cur_bank), .valid_o(cur_valid));
  brf_mode_decode u_exc_dec (.mode_i(exc_mode_i), .bank_o(exc_bank), .valid_o(exc_valid));

  brf_phys_map u_map_a (.idx_i(ra_idx_i), .bank_i(cur_bank), .phys_o(a_phys), .is_pc_o(a_pc));
  brf_phys_map u_map_b (.idx_i(rb_idx_i), .bank_i(cur_bank), .phys_o(b_phys), .is_pc_o(b_pc));
  brf_phys_map u_map_w (.idx_i(wr_idx_i), .bank_i(cur_bank), .phys_o(w_phys), .is_pc_o(w_pc));
  brf_phys_map u_map_x (.idx_i(LINK_IDX), .bank_i(exc_bank), .phys_o(x_phys), .is_pc_o(x_pc));

  brf_storage #(
    .XLEN (XLEN),
    .NPHYS(NUM_PHYS),
    .AW   (PHYS_W)
  ) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .a_addr_i(a_phys),
    .a_data_o(a_gpr),
    .b_addr_i(b_phys),
    .b_data_o(b_gpr),
    .w_en_i  (we_i && !w_pc),
    .w_addr_i(w_phys),
    .w_data_i(wr_data_i),
    .x_en_i  (exc_we_i && !x_pc),
    .x_addr_i(x_phys),
    .x_data_i(exc_link_i)
  );

  // invalid exception mode still banks into user/system copy
  logic exc_mode_unused;
  assign exc_mode_unused = exc_valid;

  assign mode_err_o      = !cur_valid;
  assign branch_valid_o  = we_i && w_pc;
  assign branch_target_o = wr_data_i & ALIGN_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
    end else if (branch_valid_o) begin
      pc_q <= branch_target_o;
    end else if (step_i) begin
      pc_q <= pc_q + XLEN'(INSN_BYTES);
    end
  end

  assign pc_o      = pc_q;
  assign pc_read   = pc_q + XLEN'(PC_OFFSET);
  assign ra_data_o = a_pc ? pc_read : a_gpr;
  assign rb_data_o = b_pc ? pc_read : b_gpr;

  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !branch_valid_o) |=> pc_o == $past(pc_o) + XLEN'(INSN_BYTES)); // R6

  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !branch_valid_o) |=> $stable(pc_o)); // R6

  AST_BRANCH_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_valid_o |=> pc_o == $past(branch_target_o)); // R5

  AST_BAD_MODE_USER_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o |-> cur_bank == BANK_USR); // R7

endmodule

// File: tb/banked_regfile_test.sv
module banked_regfile_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  mode = 5'b10000;
  logic        mode_err;
  logic [3:0]  ra_idx = '0, rb_idx = '0, wr_idx = '0;
  logic [31:0] ra_data, rb_data, wr_data = '0;
  logic        we = 1'b0, step = 1'b0, exc_we = 1'b0;
  logic [31:0] pc, br_target, exc_link = '0;
  logic        br_valid;
  logic [4:0]  exc_mode = 5'b10000;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  banked_regfile uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .mode_err_o(mode_err),
    .ra_idx_i(ra_idx), .ra_data_o(ra_data), .rb_idx_i(rb_idx), .rb_data_o(rb_data),
    .we_i(we), .wr_idx_i(wr_idx), .wr_data_i(wr_data), .step_i(step), .pc_o(pc),
    .branch_valid_o(br_valid), .branch_target_o(br_target),
    .exc_we_i(exc_we), .exc_mode_i(exc_mode), .exc_link_i(exc_link)
  );

  // behavioural reference model
  logic [31:0] m_low [8];
  logic [31:0] m_hi_usr [5];
  logic [31:0] m_hi_fiq [5];
  logic [31:0] m_sp [6];
  logic [31:0] m_lr [6];
  logic [31:0] m_pc;

  function automatic int mbank(logic [4:0] m);
    case (m)
      5'b10001: return 1;
      5'b10010: return 2;
      5'b10011: return 3;
      5'b10111: return 4;
      5'b11011: return 5;
      default:  return 0;
    endcase
  endfunction

  function automatic bit mknown(logic [4:0] m);
    return m inside {5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111};
  endfunction

  function automatic logic [31:0] mread(logic [3:0] i, logic [4:0] m);
    if (i == 15) return m_pc + 32'd8;
    if (i < 8) return m_low[i];
    if (i < 13) return (mbank(m) == 1) ? m_hi_fiq[i-8] : m_hi_usr[i-8];
    if (i == 13) return m_sp[mbank(m)];
    return m_lr[mbank(m)];
  endfunction

  task automatic mwrite(logic [3:0] i, logic [4:0] m, logic [31:0] v);
    if (i < 8) m_low[i] = v;
    else if (i < 13) begin
      if (mbank(m) == 1) m_hi_fiq[i-8] = v; else m_hi_usr[i-8] = v;
    end else if (i == 13) m_sp[mbank(m)] = v;
    else if (i == 14) m_lr[mbank(m)] = v;
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag, logic [4:0] m, logic [3:0] a, logic [3:0] b,
                     logic w, logic [3:0] wi, logic [31:0] wd, logic st,
                     logic x, logic [4:0] xm, logic [31:0] xd);
    @(negedge clk);
    mode = m; ra_idx = a; rb_idx = b; we = w; wr_idx = wi; wr_data = wd;
    step = st; exc_we = x; exc_mode = xm; exc_link = xd;
    #5;
    chk(tag, "ra_data", ra_data, mread(a, m));
    chk(tag, "rb_data", rb_data, mread(b, m));
    chk(tag, "pc", pc, m_pc);
    chk(tag, "mode_err", {31'd0, mode_err}, {31'd0, !mknown(m)});
    chk(tag, "branch_valid", {31'd0, br_valid}, {31'd0, (w && wi == 15)});
    if (w && wi == 15) chk(tag, "branch_target", br_target, wd & 32'hFFFF_FFFC);
    @(posedge clk);
    if (w && wi != 15) mwrite(wi, m, wd);
    if (x) m_lr[mbank(xm)] = xd;
    if (w && wi == 15) m_pc = wd & 32'hFFFF_FFFC;
    else if (st) m_pc = m_pc + 32'd4;
  endtask

  task automatic rd(string tag, logic [4:0] m, logic [3:0] a, logic [3:0] b);
    cyc(tag, m, a, b, 1'b0, 4'd0, 32'd0, 1'b0, 1'b0, 5'b10000, 32'd0);
  endtask

  task automatic wr(string tag, logic [4:0] m, logic [3:0] i, logic [31:0] v);
    cyc(tag, m, i, i, 1'b1, i, v, 1'b0, 1'b0, 5'b10000, 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  logic [4:0] modes [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                            5'b10111, 5'b11011, 5'b11111, 5'b00110};

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) m_low[i] = '0;
    for (int i = 0; i < 5; i++) begin m_hi_usr[i] = '0; m_hi_fiq[i] = '0; end
    for (int i = 0; i < 6; i++) begin m_sp[i] = '0; m_lr[i] = '0; end
    m_pc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state across all banks
    for (int k = 0; k < 7; k++)
      for (int i = 0; i < 15; i += 2) rd("R10", modes[k], 4'(i), 4'(i + 1));

    // R1: shared low registers
    wr("R1", 5'b10000, 4'd3, 32'h1111_0003);
    rd("R1", 5'b10001, 4'd3, 4'd3);
    rd("R1", 5'b11011, 4'd3, 4'd7);
    wr("R1", 5'b10010, 4'd7, 32'h7777_0007);
    rd("R1", 5'b11111, 4'd7, 4'd3);

    // R2: fiq copies of 8..12
    wr("R2", 5'b10001, 4'd9, 32'hF1F1_0009);
    rd("R2", 5'b10011, 4'd9, 4'd9);
    wr("R2", 5'b10011, 4'd9, 32'h5555_0009);
    rd("R2", 5'b10001, 4'd9, 4'd12);
    rd("R2", 5'b10010, 4'd9, 4'd8);

    // R3: six copies of 13 and 14
    for (int k = 0; k < 7; k++) begin
      wr("R3", modes[k], 4'd13, 32'h5000_0000 + 32'(k));
      wr("R3", modes[k], 4'd14, 32'hE000_0000 + 32'(k));
    end
    for (int k = 0; k < 7; k++) rd("R3", modes[k], 4'd13, 4'd14);

    // R6 / R4: stepping and pc reads
    for (int k = 0; k < 5; k++)
      cyc("R6", 5'b10000, 4'd15, 4'd15, 1'b0, 4'd0, 32'd0, 1'b1, 1'b0, 5'b10000, 32'd0);
    rd("R4", 5'b10011, 4'd15, 4'd0);
    rd("R6", 5'b10011, 4'd15, 4'd15);

    // R5: branch with misaligned data, step in same cycle loses
    cyc("R5", 5'b10000, 4'd15, 4'd0, 1'b1, 4'd15, 32'h0000_1003, 1'b1, 1'b0, 5'b10000, 32'd0);
    rd("R5", 5'b10000, 4'd15, 4'd0);
    rd("R5", 5'b10000, 4'd0, 4'd1);

    // R7: unknown mode code uses user/system bank
    rd("R7", 5'b00000, 4'd13, 4'd9);
    wr("R7", 5'b01010, 4'd14, 32'hBAD0_0014);
    rd("R7", 5'b10000, 4'd14, 4'd14);

    // R8: read-during-write returns old value
    wr("R8", 5'b10000, 4'd5, 32'hAAAA_0005);
    rd("R8", 5'b10000, 4'd5, 4'd5);

    // R9: exception link into irq bank from user mode, collides with normal write
    cyc("R9", 5'b10000, 4'd14, 4'd2, 1'b0, 4'd0, 32'd0, 1'b0, 1'b1, 5'b10010, 32'h1234_5678);
    rd("R9", 5'b10010, 4'd14, 4'd14);
    cyc("R9", 5'b10011, 4'd14, 4'd13, 1'b1, 4'd14, 32'hDEAD_0000, 1'b0, 1'b1, 5'b10011, 32'hC0DE_0001);
    rd("R9", 5'b10011, 4'd14, 4'd14);
    rd("R9", 5'b10000, 4'd14, 4'd14);

    // mixed traffic
    for (int n = 0; n < 400; n++) begin
      logic [4:0] m;
      logic       w, x;
      m = modes[$urandom_range(0, 7)];
      w = ($urandom_range(0, 3) != 0);
      x = ($urandom_range(0, 7) == 0);
      cyc("R8", m, 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
          w, 4'($urandom_range(0, 15)), $urandom(), 1'($urandom_range(0, 1)),
          x, modes[$urandom_range(0, 7)], $urandom());
    end

    finish_run();
  end

endmodule